// File: doc/BRIEF.md
# Partial-Line DMA Write Merge Controller

This controller sits at the directory and handles DMA writes that may cover only some bytes of a 64-byte line. It buffers the bytes being written and tracks them with a per-byte fill mask. It then issues one line read to memory and, in the same cycle, a probe to the caching agents that must give up the line. The bytes written by the DMA agent always take priority. The remaining bytes come from the freshest copy: a dirty probe response if there is one, otherwise the memory data. The finished line goes back to memory as a full-line write.

Memory data and the probe response may arrive in either order, and the fill mask decides which one wins. If memory data arrives first, it fills the bytes the DMA did not write. A dirty probe response that comes later replaces those bytes and marks the mask as full. If a dirty probe response arrives first, it marks the mask as full, so memory data that arrives later changes nothing.

Two configuration flags can remove the CPU-side agents or the GPU-side agents from the probe set. If the set ends up empty, the controller sends no probe and waits only for memory. The controller works on one line at a time and holds off new requests until the memory write is acknowledged.

Top module: `pwm_merge_ctrl`

## Requirements
- R1: After reset, `dma_req_ready` is 1, and `mem_rd_req`, `prb_req_valid`, `mem_wr_req` and `dma_ack_valid` are all 0.
- R2: In the cycle after a request is accepted (`dma_req_valid` and `dma_req_ready` both high at a clock edge), `mem_rd_req` is 1 for exactly one cycle and `mem_rd_line` equals the accepted line index.
- R3: Probe destination bits 0 to N_CPU-1 are CPU-side agents and the bits above them are GPU-side agents. `cfg_cpu_only` clears the GPU bits and `cfg_gpu_only` clears the CPU bits. A probe with this set on `prb_req_dest` is issued in the same cycle as the memory read.
- R4: When both flags are set, the destination set is empty. No probe is issued, and the write proceeds once memory data alone has arrived.
- R5: When memory data arrives first and the probe response is dirty, the written line holds the DMA bytes where `dma_req_be` bit b is 1 and the probe bytes everywhere else (byte b is bits 8b+7 to 8b).
- R6: When a dirty probe response arrives first, memory data that arrives afterwards does not change the line. Non-enabled bytes come from the probe.
- R7: When the probe response is clean (`prb_rsp_dirty` = 0), in either arrival order, the non-enabled bytes come from memory.
- R8: `mem_wr_req` and `dma_ack_valid` are 1 together for one cycle, starting in the cycle after the last awaited response. `mem_wr_line` and `dma_ack_line` carry the request's line index.
- R9: After the write is issued, `dma_req_ready` stays 0 until `mem_wr_ack` is seen. It is 1 again in the cycle after that acknowledge.
- R10: While a line is in flight, `dma_req_ready` is 0 and `dma_req_valid` is ignored. No new memory read is started by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpu_only | input | 1 | Drop GPU-side agents from probe set |
| cfg_gpu_only | input | 1 | Drop CPU-side agents from probe set |
| dma_req_valid | input | 1 | DMA write request present |
| dma_req_ready | output | 1 | Controller can accept a request |
| dma_req_line | input | LINE_AW | Line index of the write |
| dma_req_be | input | LINE_BYTES | Byte enables of the write |
| dma_req_data | input | 8*LINE_BYTES | Write data, byte-lane aligned |
| dma_ack_valid | output | 1 | Write acknowledge to the DMA agent |
| dma_ack_line | output | LINE_AW | Line index being acknowledged |
| mem_rd_req | output | 1 | Line read request to memory |
| mem_rd_line | output | LINE_AW | Line index to read |
| mem_rd_data_valid | input | 1 | Memory read data present |
| mem_rd_data | input | 8*LINE_BYTES | Memory read data |
| mem_wr_req | output | 1 | Full-line write request to memory |
| mem_wr_line | output | LINE_AW | Line index to write |
| mem_wr_data | output | 8*LINE_BYTES | Merged line |
| mem_wr_ack | input | 1 | Memory write acknowledge |
| prb_req_valid | output | 1 | Invalidating probe request |
| prb_req_line | output | LINE_AW | Line index being probed |
| prb_req_dest | output | N_CPU+N_GPU | Probe destination set |
| prb_rsp_valid | input | 1 | Collected probe response present |
| prb_rsp_dirty | input | 1 | Probe response carries modified data |
| prb_rsp_data | input | 8*LINE_BYTES | Probe response data |

## Verification
The memory read and the probe appear in the cycle after acceptance. The full-line write and the DMA acknowledge appear in the cycle after the last awaited response. `dma_req_ready` returns in the cycle after `mem_wr_ack`. The bench drives inputs on falling edges and samples each of these results at the falling edge of the cycle where it is due. The monitor compares every memory write against a scoreboard entry, built from the byte enables, the arrival order and the dirty flag, on the falling edge where `mem_wr_req` is high.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ISSUE = 3'd1,
    S_W_PM  = 3'd2,
    S_W_P   = 3'd3,
    S_W_M   = 3'd4,
    S_WR    = 3'd5,
    S_W_ACK = 3'd6
  } pwm_state_e;
endpackage

// File: rtl/pwm_dest_select.sv
module pwm_dest_select #(
  parameter int N_CPU = 4,
  parameter int N_GPU = 4,
  localparam int N_DEST = N_CPU + N_GPU
) (
  input  logic              cpu_only,
  input  logic              gpu_only,
  output logic [N_DEST-1:0] dest
);
  // low indices are CPU-side agents, upper indices GPU-side agents
  for (genvar i = 0; i < N_DEST; i++) begin : g_agent
    if (i < N_CPU) begin : g_cpu
      assign dest[i] = ~gpu_only;
    end else begin : g_gpu
      assign dest[i] = ~cpu_only;
    end
  end
endmodule

// File: rtl/pwm_byte_merge.sv
module pwm_byte_merge #(
  parameter int LINE_BYTES = 64,
  localparam int DATA_W = LINE_BYTES * 8
) (
  input  logic [LINE_BYTES-1:0] keep_mask,
  input  logic [DATA_W-1:0]     kept,
  input  logic [DATA_W-1:0]     incoming,
  output logic [DATA_W-1:0]     merged
);
  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
    assign merged[b*8 +: 8] = keep_mask[b] ? kept[b*8 +: 8] : incoming[b*8 +: 8];
  end
endmodule

// File: rtl/pwm_line_buf.sv
module pwm_line_buf #(
  parameter int LINE_BYTES = 64,
  localparam int DATA_W = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  load,
  input  logic [LINE_BYTES-1:0] load_mask,
  input  logic [DATA_W-1:0]     load_data,
  input  logic                  merge_en,
  input  logic [DATA_W-1:0]     merge_src,
  input  logic                  fill,
  output logic [DATA_W-1:0]     line,
  output logic [LINE_BYTES-1:0] mask
);
  logic [DATA_W-1:0]     line_q, line_d;
  logic [LINE_BYTES-1:0] mask_q, mask_d;
  logic [DATA_W-1:0]     merged;
  logic                  line_en;

  pwm_byte_merge #(.LINE_BYTES(LINE_BYTES)) u_merge (
    .keep_mask (mask_q),
    .kept      (line_q),
    .incoming  (merge_src),
    .merged    (merged)
  );

  assign line_en = load | merge_en;

  always_comb begin
    line_d = line_q;
    mask_d = mask_q;
    if (load) begin
      line_d = load_data;
      mask_d = load_mask;
    end else if (merge_en) begin
      line_d = merged;
      if (fill) mask_d = '1;
    end
  end

  // datapath storage: no reset, written only under its enable
  always_ff @(posedge clk) begin
    if (line_en) begin
      line_q <= line_d;
      mask_q <= mask_d;
    end
  end

  assign line = line_q;
  assign mask = mask_q;
endmodule

// File: rtl/pwm_merge_ctrl.sv
module pwm_merge_ctrl
  import pwm_pkg::*;
#(
  parameter int LINE_AW    = 26,
  parameter int LINE_BYTES = 64,
  parameter int N_CPU      = 4,
  parameter int N_GPU      = 4,
  localparam int DATA_W    = LINE_BYTES * 8,
  localparam int N_DEST    = N_CPU + N_GPU
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_cpu_only,
  input  logic                  cfg_gpu_only,
  input  logic                  dma_req_valid,
  output logic                  dma_req_ready,
  input  logic [LINE_AW-1:0]    dma_req_line,
  input  logic [LINE_BYTES-1:0] dma_req_be,
  input  logic [DATA_W-1:0]     dma_req_data,
  output logic                  dma_ack_valid,
  output logic [LINE_AW-1:0]    dma_ack_line,
  output logic                  mem_rd_req,
  output logic [LINE_AW-1:0]    mem_rd_line,
  input  logic                  mem_rd_data_valid,
  input  logic [DATA_W-1:0]     mem_rd_data,
  output logic                  mem_wr_req,
  output logic [LINE_AW-1:0]    mem_wr_line,
  output logic [DATA_W-1:0]     mem_wr_data,
  input  logic                  mem_wr_ack,
  output logic                  prb_req_valid,
  output logic [LINE_AW-1:0]    prb_req_line,
  output logic [N_DEST-1:0]     prb_req_dest,
  input  logic                  prb_rsp_valid,
  input  logic                  prb_rsp_dirty,
  input  logic [DATA_W-1:0]     prb_rsp_data
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pwm_state_e             state_q, state_d;
  logic [LINE_AW-1:0]     line_q;
  logic [N_DEST-1:0]      dest_q, dest_sel;
  logic                   accept;
  logic                   mem_ev, prb_ev;
  logic                   merge_en, merge_fill;
  logic [DATA_W-1:0]      merge_src;
  logic [LINE_BYTES-1:0]  fill_mask;
  logic                   probe_any;

  pwm_dest_select #(.N_CPU(N_CPU), .N_GPU(N_GPU)) u_dest (
    .cpu_only (cfg_cpu_only),
    .gpu_only (cfg_gpu_only),
    .dest     (dest_sel)
  );

  assign accept    = dma_req_valid & (state_q == S_IDLE);
  assign probe_any = |dest_q;

  // events are taken only in states that wait for them
  assign mem_ev = mem_rd_data_valid & ((state_q == S_W_PM) | (state_q == S_W_M));
  assign prb_ev = prb_rsp_valid     & ((state_q == S_W_PM) | (state_q == S_W_P));

  // memory fills unwritten bytes; a dirty probe overrides them and fills the mask
  assign merge_en   = mem_ev | (prb_ev & prb_rsp_dirty);
  assign merge_src  = mem_ev ? mem_rd_data : prb_rsp_data;
  assign merge_fill = ~mem_ev;

  pwm_line_buf #(.LINE_BYTES(LINE_BYTES)) u_buf (
    .clk       (clk),
    .load      (accept),
    .load_mask (dma_req_be),
    .load_data (dma_req_data),
    .merge_en  (merge_en),
    .merge_src (merge_src),
    .fill      (merge_fill),
    .line      (mem_wr_data),
    .mask      (fill_mask)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (accept) state_d = S_ISSUE;
      S_ISSUE: state_d = probe_any ? S_W_PM : S_W_M;
      S_W_PM: begin
        if (mem_ev)      state_d = S_W_P;
        else if (prb_ev) state_d = S_W_M;
      end
      S_W_P:   if (prb_ev) state_d = S_WR;
      S_W_M:   if (mem_ev) state_d = S_WR;
      S_WR:    state_d = S_W_ACK;
      S_W_ACK: if (mem_wr_ack) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= S_IDLE;
    else            state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      line_q <= dma_req_line;
      dest_q <= dest_sel;
    end
  end

  assign dma_req_ready = (state_q == S_IDLE);
  assign mem_rd_req    = (state_q == S_ISSUE);
  assign mem_rd_line   = line_q;
  assign prb_req_valid = (state_q == S_ISSUE) & probe_any;
  assign prb_req_line  = line_q;
  assign prb_req_dest  = dest_q;
  assign mem_wr_req    = (state_q == S_WR);
  assign mem_wr_line   = line_q;
  assign dma_ack_valid = (state_q == S_WR);
  assign dma_ack_line  = line_q;

  AST_ACCEPT_READ: assert property (@(posedge clk) disable iff (!rst_int_n)
    (dma_req_valid && dma_req_ready) |=> (mem_rd_req && mem_rd_line == $past(dma_req_line))); // R2
  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_rd_req |=> !mem_rd_req); // R2
  AST_PROBE_WAITS_BOTH: assert property (@(posedge clk) disable iff (!rst_int_n)
    prb_req_valid |=> (state_q == S_W_PM)); // R3
  AST_EMPTY_SET_MEM_ONLY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_rd_req && !prb_req_valid) |=> (state_q == S_W_M)); // R4
  AST_DIRTY_FILLS_MASK: assert property (@(posedge clk) disable iff (!rst_int_n)
    (prb_ev && prb_rsp_dirty && !mem_ev) |=> (fill_mask == '1)); // R6
  AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_wr_req |=> !mem_wr_req); // R8
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == S_W_ACK && !mem_wr_ack) |=> !dma_req_ready); // R9
  AST_STALL_KEEPS_LINE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (dma_req_valid && !dma_req_ready) |=> $stable(line_q)); // R10
endmodule

// File: tb/sim_pwm_merge_ctrl.sv
module sim_pwm_merge_ctrl;
  localparam int AW = 26;
  localparam int NB = 64;
  localparam int DW = NB * 8;
  localparam int NC = 4;
  localparam int NG = 4;
  localparam int ND = NC + NG;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_cpu_only, cfg_gpu_only;
  logic dma_req_valid, dma_req_ready;
  logic [AW-1:0] dma_req_line;
  logic [NB-1:0] dma_req_be;
  logic [DW-1:0] dma_req_data;
  logic dma_ack_valid;
  logic [AW-1:0] dma_ack_line;
  logic mem_rd_req;
  logic [AW-1:0] mem_rd_line;
  logic mem_rd_data_valid;
  logic [DW-1:0] mem_rd_data;
  logic mem_wr_req;
  logic [AW-1:0] mem_wr_line;
  logic [DW-1:0] mem_wr_data;
  logic mem_wr_ack;
  logic prb_req_valid;
  logic [AW-1:0] prb_req_line;
  logic [ND-1:0] prb_req_dest;
  logic prb_rsp_valid, prb_rsp_dirty;
  logic [DW-1:0] prb_rsp_data;

  always #4 clk = ~clk;

  pwm_merge_ctrl #(.LINE_AW(AW), .LINE_BYTES(NB), .N_CPU(NC), .N_GPU(NG)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_cpu_only(cfg_cpu_only), .cfg_gpu_only(cfg_gpu_only),
    .dma_req_valid(dma_req_valid), .dma_req_ready(dma_req_ready), .dma_req_line(dma_req_line),
    .dma_req_be(dma_req_be), .dma_req_data(dma_req_data), .dma_ack_valid(dma_ack_valid),
    .dma_ack_line(dma_ack_line), .mem_rd_req(mem_rd_req), .mem_rd_line(mem_rd_line),
    .mem_rd_data_valid(mem_rd_data_valid), .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req),
    .mem_wr_line(mem_wr_line), .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack),
    .prb_req_valid(prb_req_valid), .prb_req_line(prb_req_line), .prb_req_dest(prb_req_dest),
    .prb_rsp_valid(prb_rsp_valid), .prb_rsp_dirty(prb_rsp_dirty), .prb_rsp_data(prb_rsp_data)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit mon_on = 1'b0;

  logic [DW-1:0] exp_line_q[$];
  logic [AW-1:0] exp_addr_q[$];
  string         exp_tag_q[$];

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mk_line(input int seed);
    logic [DW-1:0] l;
    for (int b = 0; b < NB; b++) l[b*8 +: 8] = 8'(seed + b * 7);
    return l;
  endfunction

  // scoreboard monitor: compares each full-line write with the queued expectation
  always @(negedge clk) begin
    if (mon_on && mem_wr_req) begin
      if (exp_line_q.size() == 0) begin
        chk("R8 unexpected write", 1, 0);
      end else begin
        string t;
        logic [DW-1:0] el;
        logic [AW-1:0] ea;
        t  = exp_tag_q.pop_front();
        el = exp_line_q.pop_front();
        ea = exp_addr_q.pop_front();
        chk({t, " merged line"}, mem_wr_data, el);
        chk("R8 write line index", DW'(mem_wr_line), DW'(ea));
        chk("R8 ack with write", DW'(dma_ack_valid), 1);
        chk("R8 ack line index", DW'(dma_ack_line), DW'(ea));
      end
    end
  end

  task automatic pulse_mem(input logic [DW-1:0] d);
    mem_rd_data = d; mem_rd_data_valid = 1'b1;
    @(negedge clk);
    mem_rd_data_valid = 1'b0;
  endtask

  task automatic pulse_prb(input logic [DW-1:0] d, input bit dirty);
    prb_rsp_data = d; prb_rsp_dirty = dirty; prb_rsp_valid = 1'b1;
    @(negedge clk);
    prb_rsp_valid = 1'b0;
  endtask

  // driver: one partial write with a chosen response order
  task automatic xfer(input string tag, input logic [AW-1:0] ln, input logic [NB-1:0] be,
                      input int dseed, input int mseed, input int pseed,
                      input bit mem_first, input bit dirty, input bit co, input bit go,
                      input bit stall);
    logic [ND-1:0] dexp;
    logic [DW-1:0] d, m, p, e;
    bit probe;
    d = mk_line(dseed); m = mk_line(mseed); p = mk_line(pseed);
    if (co && go) dexp = '0;
    else if (co)  dexp = {{NG{1'b0}}, {NC{1'b1}}};
    else if (go)  dexp = {{NG{1'b1}}, {NC{1'b0}}};
    else          dexp = '1;
    probe = (dexp != '0);
    for (int b = 0; b < NB; b++)
      e[b*8 +: 8] = be[b] ? d[b*8 +: 8] : ((probe && dirty) ? p[b*8 +: 8] : m[b*8 +: 8]);

    cfg_cpu_only = co; cfg_gpu_only = go;
    chk("R9 ready before request", DW'(dma_req_ready), 1);
    dma_req_line = ln; dma_req_be = be; dma_req_data = d; dma_req_valid = 1'b1;
    @(negedge clk);
    dma_req_valid = 1'b0;
    chk("R2 read issued", DW'(mem_rd_req), 1);
    chk("R2 read line index", DW'(mem_rd_line), DW'(ln));
    chk(probe ? "R3 probe issued" : "R4 probe skipped", DW'(prb_req_valid), DW'(probe));
    if (probe) chk("R3 probe destinations", DW'(prb_req_dest), DW'(dexp));
    chk("R10 busy after accept", DW'(dma_req_ready), 0);
    exp_tag_q.push_back(tag); exp_line_q.push_back(e); exp_addr_q.push_back(ln);
    if (stall) begin
      dma_req_line = ln + 1'b1; dma_req_be = '1; dma_req_data = '0; dma_req_valid = 1'b1;
    end
    @(negedge clk);
    if (stall) begin
      chk("R10 no accept while busy", DW'(dma_req_ready), 0);
      dma_req_valid = 1'b0;
    end
    chk("R2 read is one pulse", DW'(mem_rd_req), 0);
    if (!probe) pulse_mem(m);
    else if (mem_first) begin pulse_mem(m); pulse_prb(p, dirty); end
    else begin pulse_prb(p, dirty); pulse_mem(m); end
    chk("R8 write after last response", DW'(mem_wr_req), 1);
    @(negedge clk);
    chk("R8 write is one pulse", DW'(mem_wr_req), 0);
    chk("R9 busy waiting ack", DW'(dma_req_ready), 0);
    @(negedge clk);
    chk("R9 still busy waiting ack", DW'(dma_req_ready), 0);
    chk("R10 no read from stalled request", DW'(mem_rd_req), 0);
    mem_wr_ack = 1'b1;
    @(negedge clk);
    mem_wr_ack = 1'b0;
    chk("R9 ready after ack", DW'(dma_req_ready), 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_cpu_only = 1'b0; cfg_gpu_only = 1'b0;
    dma_req_valid = 1'b0; dma_req_line = '0; dma_req_be = '0; dma_req_data = '0;
    mem_rd_data_valid = 1'b0; mem_rd_data = '0; mem_wr_ack = 1'b0;
    prb_rsp_valid = 1'b0; prb_rsp_dirty = 1'b0; prb_rsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset ready", DW'(dma_req_ready), 1);
    chk("R1 reset no read", DW'(mem_rd_req), 0);
    chk("R1 reset no probe", DW'(prb_req_valid), 0);
    chk("R1 reset no write", DW'(mem_wr_req), 0);
    chk("R1 reset no ack", DW'(dma_ack_valid), 0);
    mon_on = 1'b1;

    xfer("R5", 26'h0000123, 64'h0000_0000_0000_000F, 1, 40, 90, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    xfer("R6", 26'h0000456, 64'hF0F0_0000_0000_0FF0, 2, 41, 91, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    xfer("R7", 26'h0000789, 64'h8000_0000_0000_0001, 3, 42, 92, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    xfer("R7", 26'h00009AB, 64'h0000_FFFF_0000_0000, 4, 43, 93, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    xfer("R3", 26'h0000ABC, 64'h0000_0000_00FF_0000, 5, 44, 94, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    xfer("R3", 26'h0000DEF, 64'h1111_1111_1111_1111, 6, 45, 95, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    xfer("R4", 26'h3FFFFFF, 64'h0000_0000_0000_0100, 7, 46, 96, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    xfer("R5", 26'h0000001, 64'hFFFF_FFFF_FFFF_FFFF, 8, 47, 97, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);

    chk("R8 all writes seen", DW'(exp_line_q.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule